// File: doc/BRIEF.md
# Multi-Mode Timer Channel Counter

This block is one 16-bit timer channel. A mode select picks one of five behaviours: a periodic down-counter (interval), a down-counter stepped by pin edges (event), a free-running up-counter whose value is captured on pin edges (capture), a down-counter that runs once per pin trigger (one-shot), and an up-counter that runs once per trigger and captures on the next edge (capture one-shot). The count clock is an enable pulse from an external prescaler. The reload value comes from a register outside the block.

A start strobe arms the channel and sets the enable status. How the first step is handled depends on the mode. The periodic and one-shot modes take the reload value on the first count clock. The capture modes clear the counter on the first count clock. Event mode takes the reload value in the same cycle as the start. A stop strobe drops the enable status and freezes the counter. The timer pin passes through a two-flop synchronizer. An edge selector chooses which pin transitions count as active edges.

The mode is latched when the channel starts. A change of the mode input therefore only takes effect at the next start.

Top module: `tmr_channel`

## Requirements
- R1: After reset, `count_val` and `capture_val` are 0 and `irq_pulse` and `chan_enabled` are 0.
- R2: Interval mode (`mode_sel`=0; values 5 to 7 act the same). A start sets `chan_enabled` in the next cycle and leaves `count_val` unchanged until the first count tick. The first count tick loads `reload_val`.
- R3: Interval mode. Each later tick decrements the counter. A tick while the counter is 0 reloads `reload_val` and raises `irq_pulse` for exactly one cycle.
- R4: Event mode (`mode_sel`=1). A start loads `reload_val` at the same clock edge. Count ticks have no effect. Each active pin edge decrements the counter. An active edge while the counter is 0 reloads the counter and raises `irq_pulse`.
- R5: Capture mode (`mode_sel`=2). The counter is unchanged until the first tick after a start. That tick clears it to 0, and later ticks increment it. An active pin edge copies the counter to `capture_val`, clears the counter and raises `irq_pulse`.
- R6: In the capture modes, an active edge takes priority over a count tick that lands in the same cycle. `capture_val` gets the value from before the tick, and the counter becomes 0.
- R7: One-shot mode (`mode_sel`=3). A start while the channel is disabled enters a wait state in which ticks have no effect. An active pin edge moves the channel on. The next tick loads `reload_val`, and later ticks decrement the counter.
- R8: One-shot mode. A tick while the counter is 0 raises `irq_pulse`, keeps the counter at 0 and keeps `chan_enabled` at 1. The channel then returns to waiting for a trigger edge.
- R9: Capture one-shot mode (`mode_sel`=4). After a start, the channel waits for an active edge. The first tick after that edge clears the counter, and later ticks increment it. The next active edge captures the counter, raises `irq_pulse`, clears the counter and returns the channel to waiting.
- R10: `edge_sel` selects the active edge: 0 = rising, 1 = falling, 2 or 3 = both. A pin change is acted on at the third rising clock edge after the change.
- R11: A stop clears `chan_enabled` at the next clock edge. It freezes `count_val`, after which ticks and pin edges have no effect. A stop in the same cycle as a start wins.
- R12: A start while the channel is enabled is ignored in the one-shot modes. In the other modes it restarts that mode's start sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Count clock enable pulse |
| tin | input | 1 | Asynchronous timer input pin |
| mode_sel | input | 3 | Operating mode, latched at start |
| edge_sel | input | 2 | Active pin edge selection |
| start_req | input | 1 | Start strobe |
| stop_req | input | 1 | Stop strobe |
| reload_val | input | 16 | Reload (data) value |
| count_val | output | 16 | Current counter value |
| capture_val | output | 16 | Last captured counter value |
| irq_pulse | output | 1 | One-cycle interrupt at reload, capture or one-shot end |
| chan_enabled | output | 1 | Enable status |

## Verification
In the capture modes, a synchronized pin edge and a count tick can both reach the counter at the same clock edge. The bench forces this collision by raising the pin two cycles before it pulses the tick, so that the edge leaves the synchronizer in the tick's cycle. It then expects the capture register to hold the value from before the tick and the counter to read zero. A start and a stop are also driven together, and the enable status must stay low.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        MODE_INTERVAL    = 3'd0,
        MODE_EVENT       = 3'd1,
        MODE_CAPTURE     = 3'd2,
        MODE_ONESHOT     = 3'd3,
        MODE_CAP_ONESHOT = 3'd4
    } tmr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_TRIG,
        ST_PEND,
        ST_RUN
    } tmr_state_e;

    function automatic tmr_mode_e decode_mode(input logic [2:0] raw);
        case (raw)
            3'd1:    return MODE_EVENT;
            3'd2:    return MODE_CAPTURE;
            3'd3:    return MODE_ONESHOT;
            3'd4:    return MODE_CAP_ONESHOT;
            default: return MODE_INTERVAL;
        endcase
    endfunction

    function automatic logic is_capture(input tmr_mode_e m);
        return (m == MODE_CAPTURE) || (m == MODE_CAP_ONESHOT);
    endfunction

    function automatic logic needs_trigger(input tmr_mode_e m);
        return (m == MODE_ONESHOT) || (m == MODE_CAP_ONESHOT);
    endfunction

    // sel: 0 rising, 1 falling, 2/3 both
    function automatic logic edge_hit(input logic [1:0] sel, input logic prev, input logic cur);
        case (sel)
            2'd0:    return !prev && cur;
            2'd1:    return prev && !cur;
            default: return prev != cur;
        endcase
    endfunction

endpackage

// File: rtl/tmr_edge_detect.sv
module tmr_edge_detect
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin,
    input  logic [1:0] sel,
    output logic       hit
);

    localparam int CHAIN_LEN = SYNC_STAGES + 1;

    logic [CHAIN_LEN-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[CHAIN_LEN-2:0], pin};
        end
    end

    // chain[SYNC_STAGES-1] is the synchronized level, chain[SYNC_STAGES] its history
    assign hit = edge_hit(sel, chain[SYNC_STAGES], chain[SYNC_STAGES-1]);

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             hit,
    input  logic             start,
    input  logic             stop,
    input  tmr_mode_e        mode_in,
    input  logic [WIDTH-1:0] reload,
    output logic [WIDTH-1:0] count,
    output logic [WIDTH-1:0] cap,
    output logic             irq,
    output logic             running
);

    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    tmr_mode_e  mode_q;
    tmr_state_e state;
    logic       start_ok;

    assign start_ok = start && !(running && needs_trigger(mode_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= ZERO;
            cap     <= ZERO;
            irq     <= 1'b0;
            running <= 1'b0;
            mode_q  <= MODE_INTERVAL;
            state   <= ST_IDLE;
        end else begin
            irq <= 1'b0;
            if (stop) begin
                running <= 1'b0;
                state   <= ST_IDLE;
            end else if (start_ok) begin
                running <= 1'b1;
                mode_q  <= mode_in;
                if (needs_trigger(mode_in)) begin
                    state <= ST_WAIT_TRIG;
                end else if (mode_in == MODE_EVENT) begin
                    count <= reload;
                    state <= ST_RUN;
                end else begin
                    state <= ST_PEND;
                end
            end else begin
                case (state)
                    ST_WAIT_TRIG: begin
                        if (hit) state <= ST_PEND;
                    end
                    ST_PEND: begin
                        if (tick) begin
                            count <= is_capture(mode_q) ? ZERO : reload;
                            state <= ST_RUN;
                        end
                    end
                    ST_RUN: begin
                        if (is_capture(mode_q) && hit) begin
                            cap   <= count;
                            count <= ZERO;
                            irq   <= 1'b1;
                            if (mode_q == MODE_CAP_ONESHOT) state <= ST_WAIT_TRIG;
                        end else if (mode_q == MODE_EVENT) begin
                            if (hit) begin
                                if (count == ZERO) begin
                                    count <= reload;
                                    irq   <= 1'b1;
                                end else begin
                                    count <= count - ONE;
                                end
                            end
                        end else if (tick) begin
                            if (is_capture(mode_q)) begin
                                count <= count + ONE;
                            end else if (count == ZERO) begin
                                irq <= 1'b1;
                                if (mode_q == MODE_ONESHOT) state <= ST_WAIT_TRIG;
                                else count <= reload;
                            end else begin
                                count <= count - ONE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_STOP_DISABLES: assert property (@(posedge clk) disable iff (rst)
        stop |=> !running); // R11

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!running && !$past(running)) |-> $stable(count)); // R11

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(tick || hit)); // R3

    AST_EVENT_IGNORES_TICK: assert property (@(posedge clk) disable iff (rst)
        (running && mode_q == MODE_EVENT && !hit && !start && !stop) |=> $stable(count)); // R4

    AST_CAPTURE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (irq && is_capture(mode_q)) |-> (count == ZERO)); // R5

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_tick,
    input  logic             tin,
    input  logic [2:0]       mode_sel,
    input  logic [1:0]       edge_sel,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic [WIDTH-1:0] reload_val,
    output logic [WIDTH-1:0] count_val,
    output logic [WIDTH-1:0] capture_val,
    output logic             irq_pulse,
    output logic             chan_enabled
);

    logic      pin_hit;
    tmr_mode_e mode_dec;

    assign mode_dec = decode_mode(mode_sel);

    tmr_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk (clk),
        .rst (rst),
        .pin (tin),
        .sel (edge_sel),
        .hit (pin_hit)
    );

    tmr_count_core #(.WIDTH(WIDTH)) core_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (cnt_tick),
        .hit     (pin_hit),
        .start   (start_req),
        .stop    (stop_req),
        .mode_in (mode_dec),
        .reload  (reload_val),
        .count   (count_val),
        .cap     (capture_val),
        .irq     (irq_pulse),
        .running (chan_enabled)
    );

endmodule

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_tick = 1'b0;
    logic        tin = 1'b0;
    logic [2:0]  mode_sel = 3'd0;
    logic [1:0]  edge_sel = 2'd0;
    logic        start_req = 1'b0;
    logic        stop_req = 1'b0;
    logic [15:0] reload_val = 16'd0;
    logic [15:0] count_val, capture_val;
    logic        irq_pulse, chan_enabled;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    tmr_channel dut_i (
        .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .tin(tin),
        .mode_sel(mode_sel), .edge_sel(edge_sel), .start_req(start_req),
        .stop_req(stop_req), .reload_val(reload_val), .count_val(count_val),
        .capture_val(capture_val), .irq_pulse(irq_pulse), .chan_enabled(chan_enabled)
    );

    // {tick, irq expected, count expected} in interval mode, reload 3
    localparam logic [17:0] IVEC [8] = '{
        {1'b1, 1'b0, 16'd3}, {1'b0, 1'b0, 16'd3}, {1'b1, 1'b0, 16'd2},
        {1'b1, 1'b0, 16'd1}, {1'b1, 1'b0, 16'd0}, {1'b0, 1'b0, 16'd0},
        {1'b1, 1'b1, 16'd3}, {1'b1, 1'b0, 16'd2}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic tick_once();
        cnt_tick = 1'b1; cyc(1); cnt_tick = 1'b0;
    endtask

    task automatic do_start();
        start_req = 1'b1; cyc(1); start_req = 1'b0;
    endtask

    task automatic do_stop();
        stop_req = 1'b1; cyc(1); stop_req = 1'b0;
    endtask

    task automatic pin_set(input logic v);
        tin = v; cyc(3);
    endtask

    initial begin
        #(4 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk("R1 count", count_val, 0);
        chk("R1 capture", capture_val, 0);
        chk("R1 irq", irq_pulse, 0);
        chk("R1 enabled", chan_enabled, 0);

        // Interval: table-driven
        mode_sel = 3'd0; reload_val = 16'd3;
        do_start();
        chk("R2 enabled after start", chan_enabled, 1);
        chk("R2 count held before tick", count_val, 0);
        for (int i = 0; i < 8; i++) begin
            cnt_tick = IVEC[i][17];
            cyc(1);
            cnt_tick = 1'b0;
            chk("R3 interval count", count_val, 32'(IVEC[i][15:0]));
            chk("R3 interval irq", irq_pulse, 32'(IVEC[i][16]));
        end

        // R12 restart in interval mode
        reload_val = 16'd5;
        do_start();
        chk("R12 restart holds count", count_val, 2);
        tick_once();
        chk("R12 restart reload", count_val, 5);

        // Event mode
        do_stop();
        mode_sel = 3'd1; reload_val = 16'd2; edge_sel = 2'd0;
        do_start();
        chk("R4 immediate load", count_val, 2);
        tick_once();
        chk("R4 tick ignored", count_val, 2);
        pin_set(1'b1);
        chk("R4 edge decrement", count_val, 1);
        pin_set(1'b0);
        chk("R10 falling ignored on rising", count_val, 1);
        pin_set(1'b1);
        chk("R4 edge to zero", count_val, 0);
        pin_set(1'b0);
        pin_set(1'b1);
        chk("R4 reload at zero", count_val, 2);
        chk("R4 irq at reload", irq_pulse, 1);
        edge_sel = 2'd2;
        pin_set(1'b0);
        chk("R10 both edges falling", count_val, 1);
        tin = 1'b1; cyc(2);
        chk("R10 not yet after two edges", count_val, 1);
        cyc(1);
        chk("R10 acted on third edge", count_val, 0);
        pin_set(1'b0);
        chk("R4 reload via falling", count_val, 2);

        // Capture mode
        do_stop();
        mode_sel = 3'd2; edge_sel = 2'd0;
        do_start();
        chk("R5 count held before tick", count_val, 2);
        tick_once();
        chk("R5 first tick clears", count_val, 0);
        tick_once(); tick_once(); tick_once();
        chk("R5 increments", count_val, 3);
        pin_set(1'b1);
        chk("R5 capture value", capture_val, 3);
        chk("R5 counter cleared", count_val, 0);
        chk("R5 irq", irq_pulse, 1);
        tick_once(); tick_once();
        pin_set(1'b0);
        chk("R10 falling ignored in capture", capture_val, 3);
        chk("R5 count before collision", count_val, 2);
        tin = 1'b1; cyc(2);
        cnt_tick = 1'b1; cyc(1); cnt_tick = 1'b0;
        chk("R6 capture pre-tick value", capture_val, 2);
        chk("R6 counter zero", count_val, 0);
        chk("R6 irq", irq_pulse, 1);
        tick_once();

        // One-shot mode
        do_stop();
        chk("R11 stop clears enable", chan_enabled, 0);
        mode_sel = 3'd3; reload_val = 16'd2; edge_sel = 2'd0;
        pin_set(1'b0);
        do_start();
        chk("R7 enabled while waiting", chan_enabled, 1);
        tick_once();
        chk("R7 tick ignored while waiting", count_val, 1);
        pin_set(1'b1);
        chk("R7 trigger alone no load", count_val, 1);
        tick_once();
        chk("R7 first tick loads", count_val, 2);
        tick_once(); tick_once();
        chk("R7 decrement to zero", count_val, 0);
        tick_once();
        chk("R8 end irq", irq_pulse, 1);
        chk("R8 count held zero", count_val, 0);
        chk("R8 stays enabled", chan_enabled, 1);
        tick_once();
        chk("R8 waiting again", count_val, 0);
        pin_set(1'b0); pin_set(1'b1);
        tick_once();
        chk("R8 retrigger loads", count_val, 2);
        do_start();
        tick_once();
        chk("R12 start ignored while running", count_val, 1);
        tick_once();

        // Capture one-shot mode
        do_stop();
        mode_sel = 3'd4; edge_sel = 2'd2;
        do_start();
        tick_once(); tick_once();
        chk("R9 waiting ignores ticks", count_val, 0);
        pin_set(1'b0);
        tick_once();
        tick_once(); tick_once(); tick_once();
        chk("R9 increments after trigger", count_val, 3);
        pin_set(1'b1);
        chk("R9 capture", capture_val, 3);
        chk("R9 irq", irq_pulse, 1);
        chk("R9 cleared", count_val, 0);
        tick_once();
        chk("R9 back to waiting", count_val, 0);
        pin_set(1'b0);
        tick_once(); tick_once();
        chk("R9 second run", count_val, 1);

        // Stop behaviour
        do_stop();
        chk("R11 disabled", chan_enabled, 0);
        tick_once(); pin_set(1'b1);
        chk("R11 count frozen", count_val, 1);
        chk("R11 capture frozen", capture_val, 3);
        start_req = 1'b1; stop_req = 1'b1; cyc(1);
        start_req = 1'b0; stop_req = 1'b0;
        chk("R11 stop wins over start", chan_enabled, 0);

        // Reset mid-run
        mode_sel = 3'd0; do_start(); tick_once();
        rst = 1'b1; cyc(1); rst = 1'b0; cyc(1);
        chk("R1 reset count", count_val, 0);
        chk("R1 reset enable", chan_enabled, 0);
        chk("R1 reset capture", capture_val, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule